// File: doc/BRIEF.md
# General-Purpose Register File with Zero Entry

This block is the operand store of a simple processor datapath. It holds a parameterizable number of entries (32 by default), each `DATA_W` bits wide. Two read ports each return one entry combinationally. One write port, plus an optional second one, updates entries on the rising clock edge. Entry 0 has no storage behind it. It always reads as zero, which gives the datapath a free constant-zero operand and a harmless destination for no-op writes.

Two parameters fix the configuration at build time. `DUAL_WRITE` adds the second write port. When both write ports name the same entry in one cycle, port 1 wins. `RDW` sets what a read returns when it names an entry that is being written in the same cycle. `RD_NEW` returns the incoming data (forwarding). `RD_OLD` returns the value already stored, and the new value becomes visible from the next cycle. The block has no state machine. Its only sequential state is the array of entries 1 to `NUM_REGS-1`.

Top module: `gprf_file`

## Requirements
- R1: With default parameters there are 32 entries, and every port uses a 5-bit address. The two read ports are independent. In the same cycle they may name the same entry or different entries, and each returns the addressed entry combinationally.
- R2: An entry changes only on a rising clock edge in which an enabled write port addresses it. When every write enable is low, all entries hold their values.
- R3: Entry 0 always reads 0 on both read ports. Writes to it are discarded, including a nonzero write followed at once by a read.
- R4: With `RDW = RD_NEW`, a read of an entry that an enabled write port is writing in the same cycle returns the incoming data. The exception is entry 0, which still reads 0.
- R5: With `RDW = RD_OLD`, a read of an entry being written in the same cycle returns the previously stored value. The new value is returned from the following cycle.
- R6: With `DUAL_WRITE = 1`, when both enabled write ports name the same nonzero entry, port 1's data is stored. In `RD_NEW` mode, port 1's data is also the value forwarded.
- R7: With `DUAL_WRITE = 1`, two enabled writes to different nonzero entries both land on the same clock edge.
- R8: With `DUAL_WRITE = 0`, the port-1 write inputs have no effect on any entry or read output.
- R9: A synchronous active-high reset clears entries 1 to `NUM_REGS-1` to zero.
- R10: A write changes only the addressed entry. All other entries keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes occur on its rising edge |
| rst | input | 1 | Synchronous active-high reset of all stored entries |
| rd_a_addr | input | ADDR_W (5) | Entry selected by read port A |
| rd_a_data | output | DATA_W | Data returned by read port A |
| rd_b_addr | input | ADDR_W (5) | Entry selected by read port B |
| rd_b_data | output | DATA_W | Data returned by read port B |
| wr0_en | input | 1 | Write port 0 enable |
| wr0_addr | input | ADDR_W (5) | Write port 0 destination entry |
| wr0_data | input | DATA_W | Write port 0 data |
| wr1_en | input | 1 | Write port 1 enable (used only when DUAL_WRITE=1) |
| wr1_addr | input | ADDR_W (5) | Write port 1 destination entry |
| wr1_data | input | DATA_W | Write port 1 data; wins same-entry conflicts |

## Verification
The bench drives two instances with identical stimulus.
- `u0` is built with `DUAL_WRITE=1` and `RDW=RD_NEW`. It covers same-cycle forwarding, same-entry write conflicts and simultaneous writes to different entries.
- `u1` is built with `DUAL_WRITE=0` and `RDW=RD_OLD`. It covers old-value reads during a write and shows that the idle second write port is ignored.

Both use 32 entries of 32 bits. Random addresses are biased toward a few low entries so that read/write collisions and hits on entry 0 happen often.

// File: rtl/gprf_pkg.sv
package gprf_pkg;

    // Read-during-write policy of the read ports
    typedef enum logic {
        RD_OLD = 1'b0,
        RD_NEW = 1'b1
    } rdw_policy_e;

endpackage

// File: rtl/gprf_wr_decode.sv
// Decodes the write ports into per-entry one-hot strobes.
// Entry 0 never receives a strobe; port 1 masks port 0 on a shared target.
module gprf_wr_decode #(
    parameter int NUM_REGS   = 32,
    parameter bit DUAL_WRITE = 1'b1,
    localparam int ADDR_W    = $clog2(NUM_REGS)
) (
    input  logic                en0,
    input  logic [ADDR_W-1:0]   addr0,
    input  logic                en1,
    input  logic [ADDR_W-1:0]   addr1,
    output logic [NUM_REGS-1:0] sel0,
    output logic [NUM_REGS-1:0] sel1
);

    logic [NUM_REGS-1:0] raw0;

    always_comb begin
        raw0 = '0;
        for (int i = 1; i < NUM_REGS; i++) begin
            raw0[i] = en0 && (addr0 == ADDR_W'(i));
        end
    end

    generate
        if (DUAL_WRITE) begin : g_dual
            always_comb begin
                sel1 = '0;
                for (int i = 1; i < NUM_REGS; i++) begin
                    sel1[i] = en1 && (addr1 == ADDR_W'(i));
                end
            end
        end else begin : g_single
            logic unused_port1;
            assign unused_port1 = ^{en1, addr1};
            assign sel1 = '0;
        end
    endgenerate

    // fixed priority: port 1 beats port 0
    assign sel0 = raw0 & ~sel1;

endmodule

// File: rtl/gprf_storage.sv
// Entry array; entry 0 is a constant, entries above it are flops.
module gprf_storage #(
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 32
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [NUM_REGS-1:0]              sel0,
    input  logic [NUM_REGS-1:0]              sel1,
    input  logic [DATA_W-1:0]                d0,
    input  logic [DATA_W-1:0]                d1,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  q
);

    logic unused_sel;
    assign unused_sel = sel0[0] ^ sel1[0];

    generate
        for (genvar i = 0; i < NUM_REGS; i++) begin : g_entry
            if (i == 0) begin : g_zero
                assign q[i] = '0;
            end else begin : g_flop
                logic [DATA_W-1:0] value;
                always_ff @(posedge clk) begin
                    if (rst) begin
                        value <= '0;
                    end else if (sel1[i]) begin
                        value <= d1;
                    end else if (sel0[i]) begin
                        value <= d0;
                    end
                end
                assign q[i] = value;
            end
        end
    endgenerate

endmodule

// File: rtl/gprf_read_port.sv
// One read port: entry select plus optional same-cycle forwarding.
module gprf_read_port
    import gprf_pkg::*;
#(
    parameter int          NUM_REGS = 32,
    parameter int          DATA_W   = 32,
    parameter rdw_policy_e RDW      = RD_NEW,
    localparam int         ADDR_W   = $clog2(NUM_REGS)
) (
    input  logic [ADDR_W-1:0]                addr,
    input  logic [NUM_REGS-1:0][DATA_W-1:0]  q,
    input  logic [NUM_REGS-1:0]              sel0,
    input  logic [NUM_REGS-1:0]              sel1,
    input  logic [DATA_W-1:0]                d0,
    input  logic [DATA_W-1:0]                d1,
    output logic [DATA_W-1:0]                data
);

    generate
        if (RDW == RD_NEW) begin : g_fwd
            // strobes already exclude entry 0 and carry port priority
            always_comb begin
                if (sel1[addr]) begin
                    data = d1;
                end else if (sel0[addr]) begin
                    data = d0;
                end else begin
                    data = q[addr];
                end
            end
        end else begin : g_old
            logic unused_fwd;
            assign unused_fwd = ^{sel0, sel1, d0, d1};
            assign data = q[addr];
        end
    endgenerate

endmodule

// File: rtl/gprf_file.sv
module gprf_file
    import gprf_pkg::*;
#(
    parameter int          NUM_REGS   = 32,
    parameter int          DATA_W     = 32,
    parameter bit          DUAL_WRITE = 1'b1,
    parameter rdw_policy_e RDW        = RD_NEW
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [$clog2(NUM_REGS)-1:0]   rd_a_addr,
    output logic [DATA_W-1:0]             rd_a_data,
    input  logic [$clog2(NUM_REGS)-1:0]   rd_b_addr,
    output logic [DATA_W-1:0]             rd_b_data,
    input  logic                          wr0_en,
    input  logic [$clog2(NUM_REGS)-1:0]   wr0_addr,
    input  logic [DATA_W-1:0]             wr0_data,
    input  logic                          wr1_en,
    input  logic [$clog2(NUM_REGS)-1:0]   wr1_addr,
    input  logic [DATA_W-1:0]             wr1_data
);

    localparam int ADDR_W = $clog2(NUM_REGS);

    logic [NUM_REGS-1:0]             sel0;
    logic [NUM_REGS-1:0]             sel1;
    logic [NUM_REGS-1:0][DATA_W-1:0] q;
    logic [1:0][ADDR_W-1:0]          rd_addr;
    logic [1:0][DATA_W-1:0]          rd_data;

    gprf_wr_decode #(
        .NUM_REGS  (NUM_REGS),
        .DUAL_WRITE(DUAL_WRITE)
    ) u_dec (
        .en0  (wr0_en),
        .addr0(wr0_addr),
        .en1  (wr1_en),
        .addr1(wr1_addr),
        .sel0 (sel0),
        .sel1 (sel1)
    );

    gprf_storage #(
        .NUM_REGS(NUM_REGS),
        .DATA_W  (DATA_W)
    ) u_store (
        .clk (clk),
        .rst (rst),
        .sel0(sel0),
        .sel1(sel1),
        .d0  (wr0_data),
        .d1  (wr1_data),
        .q   (q)
    );

    assign rd_addr[0] = rd_a_addr;
    assign rd_addr[1] = rd_b_addr;

    generate
        for (genvar p = 0; p < 2; p++) begin : g_rd
            gprf_read_port #(
                .NUM_REGS(NUM_REGS),
                .DATA_W  (DATA_W),
                .RDW     (RDW)
            ) u_rp (
                .addr(rd_addr[p]),
                .q   (q),
                .sel0(sel0),
                .sel1(sel1),
                .d0  (wr0_data),
                .d1  (wr1_data),
                .data(rd_data[p])
            );
        end
    endgenerate

    assign rd_a_data = rd_data[0];
    assign rd_b_data = rd_data[1];

endmodule

// File: rtl/gprf_file_chk.sv
module gprf_file_chk
    import gprf_pkg::*;
#(
    parameter int          NUM_REGS   = 32,
    parameter int          DATA_W     = 32,
    parameter bit          DUAL_WRITE = 1'b1,
    parameter rdw_policy_e RDW        = RD_NEW,
    localparam int         ADDR_W     = $clog2(NUM_REGS)
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] rd_a_addr,
    input logic [DATA_W-1:0] rd_a_data,
    input logic [ADDR_W-1:0] rd_b_addr,
    input logic [DATA_W-1:0] rd_b_data,
    input logic              wr0_en,
    input logic [ADDR_W-1:0] wr0_addr,
    input logic [DATA_W-1:0] wr0_data,
    input logic              wr1_en,
    input logic [ADDR_W-1:0] wr1_addr,
    input logic [DATA_W-1:0] wr1_data
);

    logic w1_live;
    logic hit_a;
    logic hit_b;
    logic clash;

    assign w1_live = DUAL_WRITE && wr1_en;
    assign hit_a   = (wr0_en && wr0_addr != '0 && wr0_addr == rd_a_addr) ||
                     (w1_live && wr1_addr != '0 && wr1_addr == rd_a_addr);
    assign hit_b   = (wr0_en && wr0_addr != '0 && wr0_addr == rd_b_addr) ||
                     (w1_live && wr1_addr != '0 && wr1_addr == rd_b_addr);
    assign clash   = wr0_en && w1_live && wr0_addr == wr1_addr;

    // R3
    zero_a_chk: assert property (@(posedge clk) disable iff (rst)
        rd_a_addr == '0 |-> rd_a_data == '0);

    // R3
    zero_b_chk: assert property (@(posedge clk) disable iff (rst)
        rd_b_addr == '0 |-> rd_b_data == '0);

    // R4
    fwd_new_chk: assert property (@(posedge clk) disable iff (rst)
        (RDW == RD_NEW && wr0_en && wr0_addr != '0 && wr0_addr == rd_a_addr && !clash)
        |-> rd_a_data == wr0_data);

    // R6
    fwd_prio_chk: assert property (@(posedge clk) disable iff (rst)
        (RDW == RD_NEW && w1_live && wr1_addr != '0 && wr1_addr == rd_b_addr)
        |-> rd_b_data == wr1_data);

    // R2
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wr0_en) && !(DUAL_WRITE && $past(wr1_en)) &&
         rd_a_addr == $past(rd_a_addr) && (RDW == RD_OLD || !hit_a))
        |-> rd_a_data == $past(rd_a_data));

    // R5
    land_next_chk: assert property (@(posedge clk) disable iff (rst)
        (RDW == RD_OLD && !$past(rst) && $past(wr0_en) && $past(wr0_addr) != '0 &&
         rd_a_addr == $past(wr0_addr) &&
         !(DUAL_WRITE && $past(wr1_en) && $past(wr1_addr) == $past(wr0_addr)))
        |-> rd_a_data == $past(wr0_data));

    // R6
    prio_land_chk: assert property (@(posedge clk) disable iff (rst)
        (DUAL_WRITE && !$past(rst) && $past(clash) && $past(wr1_addr) != '0 &&
         rd_b_addr == $past(wr1_addr) && (RDW == RD_OLD || !hit_b))
        |-> rd_b_data == $past(wr1_data));

endmodule

bind gprf_file gprf_file_chk #(
    .NUM_REGS  (NUM_REGS),
    .DATA_W    (DATA_W),
    .DUAL_WRITE(DUAL_WRITE),
    .RDW       (RDW)
) u_chk (.*);

// File: tb/sim_gprf_file.sv
module sim_gprf_file;
    import gprf_pkg::*;

    localparam int N = 32;
    localparam int W = 32;
    localparam int A = 5;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [A-1:0] ra, rb, wa0, wa1;
    logic         we0, we1;
    logic [W-1:0] wd0, wd1;
    logic [W-1:0] a0, b0, a1, b1;

    logic [W-1:0] m0 [N];
    logic [W-1:0] m1 [N];

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    gprf_file #(.NUM_REGS(N), .DATA_W(W), .DUAL_WRITE(1'b1), .RDW(RD_NEW)) u0 (
        .clk(clk), .rst(rst),
        .rd_a_addr(ra), .rd_a_data(a0), .rd_b_addr(rb), .rd_b_data(b0),
        .wr0_en(we0), .wr0_addr(wa0), .wr0_data(wd0),
        .wr1_en(we1), .wr1_addr(wa1), .wr1_data(wd1));

    gprf_file #(.NUM_REGS(N), .DATA_W(W), .DUAL_WRITE(1'b0), .RDW(RD_OLD)) u1 (
        .clk(clk), .rst(rst),
        .rd_a_addr(ra), .rd_a_data(a1), .rd_b_addr(rb), .rd_b_data(b1),
        .wr0_en(we0), .wr0_addr(wa0), .wr0_data(wd0),
        .wr1_en(we1), .wr1_addr(wa1), .wr1_data(wd1));

    // expected read of the dual-write, forwarding instance
    function automatic logic [W-1:0] exp_fwd(input logic [A-1:0] a);
        if (a == 0) return '0;
        if (we1 && wa1 == a) return wd1;
        if (we0 && wa0 == a) return wd0;
        return m0[a];
    endfunction

    // expected read of the single-write, old-value instance
    function automatic logic [W-1:0] exp_old(input logic [A-1:0] a);
        if (a == 0) return '0;
        return m1[a];
    endfunction

    function automatic string auto_tag(input bit inst, input logic [A-1:0] a);
        if (a == 0) return "R3";
        if (inst == 0 && we1 && wa1 == a && we0 && wa0 == a) return "R6";
        if (inst == 0 && ((we0 && wa0 == a) || (we1 && wa1 == a))) return "R4";
        if (inst == 1 && we0 && wa0 == a) return "R5";
        return "R10";
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // inputs are already set at a falling edge; check, then clock once
    task automatic step(input string tag);
        #1;
        check(tag == "" ? auto_tag(0, ra) : tag, "u0 port A", a0, exp_fwd(ra));
        check(tag == "" ? auto_tag(0, rb) : tag, "u0 port B", b0, exp_fwd(rb));
        check(tag == "" ? auto_tag(1, ra) : tag, "u1 port A", a1, exp_old(ra));
        check(tag == "" ? auto_tag(1, rb) : tag, "u1 port B", b1, exp_old(rb));
        @(posedge clk);
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                m0[i] = '0;
                m1[i] = '0;
            end
        end else begin
            if (we0 && wa0 != 0) begin
                m0[wa0] = wd0;
                m1[wa0] = wd0;
            end
            if (we1 && wa1 != 0) m0[wa1] = wd1;
        end
        @(negedge clk);
    endtask

    task automatic set_wr(input logic e0, input logic [A-1:0] x0, input logic [W-1:0] d0,
                          input logic e1, input logic [A-1:0] x1, input logic [W-1:0] d1);
        we0 = e0; wa0 = x0; wd0 = d0;
        we1 = e1; wa1 = x1; wd1 = d1;
    endtask

    task automatic idle();
        set_wr(1'b0, '0, '0, 1'b0, '0, '0);
    endtask

    task automatic sweep(input string tag);
        idle();
        for (int i = 0; i < N; i += 2) begin
            ra = A'(i);
            rb = A'(i + 1);
            step(tag);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle();
        ra = '0; rb = '0;
        @(negedge clk);
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            m0[i] = '0;
            m1[i] = '0;
        end
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        // R9: every entry reads zero after reset
        sweep("R9");

        // R3: write nonzero to entry 0, read it the same and the next cycle
        set_wr(1'b1, 5'd0, 32'hDEAD_BEEF, 1'b1, 5'd0, 32'hCAFE_F00D);
        ra = 5'd0; rb = 5'd0;
        step("R3");
        idle();
        step("R3");

        // R1: fill entries, then read with both ports on the same and different entries
        for (int i = 1; i < N; i++) begin
            set_wr(1'b1, A'(i), 32'h1000_0000 + i, 1'b0, '0, '0);
            ra = A'(i); rb = A'(i);
            step("");
        end
        idle();
        ra = 5'd7; rb = 5'd7;
        step("R1");
        ra = 5'd3; rb = 5'd30;
        step("R1");

        // R2: data and addresses present but enables low
        set_wr(1'b0, 5'd9, 32'h5555_AAAA, 1'b0, 5'd9, 32'hAAAA_5555);
        ra = 5'd9; rb = 5'd9;
        step("R2");
        step("R2");

        // R4 / R5: same-cycle read of the entry being written
        set_wr(1'b1, 5'd12, 32'h0BAD_C0DE, 1'b0, '0, '0);
        ra = 5'd12; rb = 5'd11;
        step("");
        idle();
        step("R5");

        // R6 / R8: both ports target one entry
        set_wr(1'b1, 5'd20, 32'h0000_0A0A, 1'b1, 5'd20, 32'h0000_0B0B);
        ra = 5'd20; rb = 5'd20;
        step("R6");
        idle();
        step("R6");

        // R7 / R8: two different entries in one cycle
        set_wr(1'b1, 5'd4, 32'h4444_0000, 1'b1, 5'd5, 32'h5555_0000);
        ra = 5'd4; rb = 5'd5;
        step("");
        idle();
        step("R7");

        // R8: port 1 alone, single-write instance must not change
        set_wr(1'b0, '0, '0, 1'b1, 5'd6, 32'h6666_6666);
        ra = 5'd6; rb = 5'd6;
        step("R8");
        idle();
        step("R8");

        // R10: constrained random traffic, biased to low entries
        for (int k = 0; k < 3000; k++) begin
            logic [A-1:0] pick [4];
            for (int j = 0; j < 4; j++) begin
                pick[j] = ($urandom_range(0, 3) == 0) ? A'($urandom_range(0, N - 1))
                                                      : A'($urandom_range(0, 5));
            end
            set_wr(($urandom_range(0, 2) != 0), pick[0], $urandom(),
                   ($urandom_range(0, 2) == 0), pick[1], $urandom());
            ra = pick[2];
            rb = pick[3];
            step("");
        end

        // R9: reset after traffic clears every entry
        do_reset();
        sweep("R9");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule